// File: doc/BRIEF.md
# Select-Strobed Output Port Latch

This block is a byte-wide output port that takes a value from a processor data bus and presents it to a peripheral. It has no write clock of its own. Three device-select lines form the write strobe: the first two are active-high and the third is active-low. While all three are asserted, the port is transparent and the output follows the data bus. When any one of them drops, the port keeps the last value it captured. The output is always driven.

A clear input empties the port to zero, but only while the strobe is inactive. If clear and strobe are both active, the strobe takes priority and the data flows through. In this on-chip version the stored value sits in a flop that loads on the block clock. The transparent path and the clear path are combinational to the output, so both act within the same cycle, as a level-sensitive latch would. An active-low asynchronous reset empties the register at power-on.

Top module: `sel_out_port`

## Requirements
- R1: While reset is asserted, and after it is released with the strobe inactive and nothing yet written, data_o is 0.
- R2: The strobe is active exactly when sel_i[0]=1, sel_i[1]=1 and sel_i[2]=0 (sel_i == 3'b011). While it is active, data_o equals data_i in the same cycle.
- R3: When the strobe is active at a clock edge, the value of data_i at that edge is stored. data_o then shows it while the strobe is inactive and clr_i is low.
- R4: Every one of the seven sel_i values other than 3'b011 leaves the stored value unchanged, whatever data_i does.
- R5: While clr_i=1 and the strobe is inactive, data_o is 0 in the same cycle. After the next edge the stored value is 0, so data_o stays 0 once clr_i is released.
- R6: While clr_i=1 and the strobe is active, data_o follows data_i, and data_i is stored at the edge. The clear has no effect.
- R7: After reset, data_o never carries an X or Z bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock; the stored value loads on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset; empties the register |
| sel_i | input | 3 | Device selects: [0] and [1] active-high, [2] active-low |
| clr_i | input | 1 | Level clear, honoured only while the strobe is inactive |
| data_i | input | 8 | Byte from the processor data bus |
| data_o | output | 8 | Byte driven to the peripheral, never high-impedance |

## Verification
The two functions that can fall in the same cycle are the clear and the write strobe. Their order of precedence is the part that is easiest to get wrong. The bench drives clr_i high in cycles where the select pattern is complete, with fresh data on the bus. It expects the output to follow the bus in that cycle and the written byte to survive after both inputs drop. It also drives clr_i with each incomplete select pattern and expects an immediate zero. A behavioural model compares data_o with its expected value on every cycle, including a long stretch of random select, clear and data patterns.

// File: rtl/sel_out_port_pkg.sv
package sel_out_port_pkg;
  localparam int unsigned PORT_W  = 8;
  localparam int unsigned SEL_N   = 3;
  // bit set = select is active-high
  localparam logic [SEL_N-1:0] SEL_POL = 3'b011;
endpackage

// File: rtl/sel_strobe_dec.sv
module sel_strobe_dec #(
  parameter int unsigned SEL_N = 3,
  parameter logic [SEL_N-1:0] SEL_POL = '1
) (
  input  logic [SEL_N-1:0] sel_i,
  output logic             strb_o
);
  logic [SEL_N-1:0] act;

  for (genvar g = 0; g < SEL_N; g++) begin : g_sel
    if (SEL_POL[g]) begin : g_hi
      assign act[g] = sel_i[g];
    end else begin : g_lo
      assign act[g] = ~sel_i[g];
    end
  end

  assign strb_o = &act;
endmodule

// File: rtl/sel_hold_reg.sv
module sel_hold_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         strb_i,
  input  logic         clr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (strb_i) q_o <= d_i;
    else if (clr_i)  q_o <= '0;
  end
endmodule

// File: rtl/sel_out_mux.sv
module sel_out_mux #(
  parameter int unsigned W = 8
) (
  input  logic         strb_i,
  input  logic         clr_i,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] q_i,
  output logic [W-1:0] y_o
);
  // strobe outranks clear; both act within the cycle
  always_comb begin
    if (strb_i)     y_o = d_i;
    else if (clr_i) y_o = '0;
    else            y_o = q_i;
  end
endmodule

// File: rtl/sel_out_port.sv
module sel_out_port
  import sel_out_port_pkg::*;
#(
  parameter int unsigned W = PORT_W,
  parameter int unsigned NS = SEL_N,
  parameter logic [NS-1:0] POL = SEL_POL
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NS-1:0] sel_i,
  input  logic          clr_i,
  input  logic [W-1:0]  data_i,
  output logic [W-1:0]  data_o
);
  logic         strb;
  logic [W-1:0] held_q;

  sel_strobe_dec #(.SEL_N(NS), .SEL_POL(POL)) u_dec (
    .sel_i  (sel_i),
    .strb_o (strb)
  );

  sel_hold_reg #(.W(W)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .strb_i (strb),
    .clr_i  (clr_i),
    .d_i    (data_i),
    .q_o    (held_q)
  );

  sel_out_mux #(.W(W)) u_mux (
    .strb_i (strb),
    .clr_i  (clr_i),
    .d_i    (data_i),
    .q_i    (held_q),
    .y_o    (data_o)
  );
endmodule

// File: rtl/sel_out_port_chk.sv
module sel_out_port_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [2:0]   sel_i,
  input logic         clr_i,
  input logic [W-1:0] data_i,
  input logic [W-1:0] data_o
);
  logic wr;
  assign wr = (sel_i == 3'b011);

  // R2
  transparent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr |-> data_o == data_i);

  // R3
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr |=> (wr || clr_i || data_o == $past(data_i)));

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr && !clr_i && $past(!wr && !clr_i)) |-> $stable(data_o));

  // R5
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !wr) |-> data_o == '0);

  // R7
  known_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(data_o));
endmodule

bind sel_out_port sel_out_port_chk #(.W(W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sel_i  (sel_i),
  .clr_i  (clr_i),
  .data_i (data_i),
  .data_o (data_o)
);

// File: tb/sel_out_port_tb_top.sv
module sel_out_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic [2:0] sel;
  logic       clr;
  logic [7:0] din;
  logic [7:0] dout;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] model = 8'h00;

  always #2 clk = ~clk;

  sel_out_port dut_i (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .clr_i  (clr),
    .data_i (din),
    .data_o (dout)
  );

  task automatic check(input string req, input logic [7:0] exp);
    n_chk++;
    if (dout !== exp) begin
      n_err++;
      $display("FAIL %s: data_o=%h expected=%h", req, dout, exp);
    end
  endtask

  // drive one cycle, compare, then advance the model past the next edge
  task automatic step(input logic [2:0] s, input logic c, input logic [7:0] d,
                      input string req);
    logic [7:0] exp;
    logic w;
    @(negedge clk);
    sel = s; clr = c; din = d;
    #1;
    w = (s[0] && s[1] && !s[2]);
    if (w)      exp = d;
    else if (c) exp = 8'h00;
    else        exp = model;
    check(req, exp);
    if (w)      model = d;
    else if (c) model = 8'h00;
  endtask

  initial begin
    fork
      begin
        rst_ni = 1'b0; sel = 3'b011; clr = 1'b0; din = 8'hFF;
        repeat (2) @(negedge clk);
        sel = 3'b000;
        #1;
        check("R1 in reset", 8'h00);
        @(negedge clk);
        rst_ni = 1'b1;
        #1;
        check("R1 after reset", 8'h00);

        // R2/R3 write and hold
        step(3'b011, 1'b0, 8'hA5, "R2 transparent");
        step(3'b011, 1'b0, 8'h5A, "R2 follows");
        step(3'b001, 1'b0, 8'h11, "R3 hold");
        step(3'b000, 1'b0, 8'h22, "R3 hold");

        // R4 every incomplete select pattern
        for (int p = 0; p < 8; p++) begin
          if (p != 3) step(3'(p), 1'b0, 8'(p * 37 + 1), "R4 partial select");
        end
        step(3'b010, 1'b0, 8'hEE, "R4 single-select glitch");
        step(3'b111, 1'b0, 8'hEE, "R4 active-low select blocks");

        // R5 clear with strobe inactive
        step(3'b001, 1'b1, 8'h77, "R5 clear immediate");
        step(3'b000, 1'b0, 8'h77, "R5 cleared held");
        step(3'b011, 1'b0, 8'h3C, "R3 rewrite");
        for (int p = 0; p < 8; p++) begin
          if (p != 3) begin
            step(3'(p), 1'b1, 8'hC3, "R5 clear per pattern");
            step(3'b011, 1'b0, 8'h3C, "R3 reload");
          end
        end

        // R6 clear and strobe together
        step(3'b011, 1'b1, 8'h0F, "R6 strobe wins");
        step(3'b100, 1'b0, 8'h99, "R6 written value kept");
        step(3'b011, 1'b1, 8'hF0, "R6 strobe wins again");
        step(3'b011, 1'b0, 8'h81, "R6 strobe only");
        step(3'b000, 1'b0, 8'h00, "R6 kept");

        // R7 and mixed traffic
        for (int i = 0; i < 400; i++) begin
          step(3'($urandom_range(0, 7)), 1'($urandom_range(0, 3) == 0),
               8'($urandom), "R7 random mix");
          if ($isunknown(dout)) begin
            n_err++;
            $display("FAIL R7: data_o=%h expected=known", dout);
          end
        end
      end
      begin
        repeat (50000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: data_o=%h expected=completion", dout);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule